// File: doc/BRIEF.md
# Ping-Pong Pattern Buffer Loader

This block takes a stream of 16-bit pattern words from a host transfer port and writes them into one half of a two-buffer pattern store. The other half is being played by an output sequencer at the same time. The sequencer reports which half it is playing on `seqActiveSel`. The loader always writes the opposite half, so a pattern can be prepared while the current one keeps running, and the running buffer is never disturbed.

The host first writes the number of words to expect. This arms the loader. Each accepted word is written at the next address, starting from zero. When the counted words equal the armed length, the loader pulses `done`, disarms and returns to idle. It also tells the sequencer that the spare buffer holds a complete pattern. If the sequencer swaps halves while a load is still running, a sticky error flag is set, because the half being filled has just become the one being played. The host clears that flag.

Top module: `pattern_loader`

## Requirements
- R1: After reset, `inReady`, `busy`, `done`, `overrunErr`, `preloadFull` and both bits of `memWe` are 0.
- R2: The loader arms in the cycle after a `lenWe` pulse that arrives while it is idle and carries a length from 1 to 4096. Armed means `inReady` = 1. A length above 4096 is ignored, and so is any `lenWe` while the loader is armed or loading. An ignored write leaves the armed length and the readiness unchanged.
- R3: A `lenWe` with length 0 in idle makes `done` 1 for exactly the next cycle. It writes nothing, and `inReady` stays 0.
- R4: A word is accepted when `inValid` and `inReady` are both 1. It is written in the same cycle: `memData` equals `inData`, and `memAddr` equals the number of words accepted earlier in this transfer, starting at 0.
- R5: Each write asserts exactly one enable, and that enable selects the buffer opposite `seqActiveSel` in that cycle. `memWe` = 2'b10 when `seqActiveSel` = 0, and 2'b01 when `seqActiveSel` = 1.
- R6: In the cycle after the word that brings the count to the armed length is accepted, `done` is 1 for one cycle and `inReady` and `busy` are 0.
- R7: `busy` is 1 from the cycle after the first accepted word until the completing word is accepted. It never rises for a one-word transfer.
- R8: If `seqActiveSel` changes while `busy` is 1, `overrunErr` is 1 from the next cycle on. It stays 1 until a cycle with `errClear` = 1 and no new overrun. A new overrun wins over a clear in the same cycle. A change while not busy has no effect on the flag.
- R9: `preloadFull` becomes 1 together with `done`. It becomes 0 in the cycle after `seqActiveSel` changes, unless a completion falls in that same cycle.
- R10: While `inReady` is 0, `inValid` causes no write (`memWe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lenWe | input | 1 | Host strobe for the expected length |
| lenData | input | 13 | Expected number of words |
| inValid | input | 1 | Host word present |
| inData | input | 16 | Host word |
| inReady | output | 1 | Loader armed and accepting words |
| seqActiveSel | input | 1 | Buffer the sequencer is currently playing |
| errClear | input | 1 | Clears the overrun flag |
| memWe | output | 2 | Per-buffer write enable |
| memAddr | output | 12 | Write address |
| memData | output | 16 | Write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| overrunErr | output | 1 | Sticky swap-during-load error |
| preloadFull | output | 1 | Spare buffer holds a complete pattern |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a buffer swap by the sequencer and the acceptance of a word. The bench flips `seqActiveSel` in the same cycle as a chosen word, including the last one. It then checks three things: the write goes to the newly spare half, `overrunErr` rises only when `busy` was already high, and completion still happens on schedule.

The second pair is a host clear of the error flag and a new overrun. The bench drives `errClear` together with a swap and expects the flag to stay set. It also pulses `errClear` alone and expects the flag to drop.

// File: rtl/pattern_loader_pkg.sv
package pattern_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LOAD  = 2'd2
  } loadState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lenLoad;  // latch new length, restart count
    logic cntInc;   // word accepted, advance address
    logic wrEn;     // write current word to the spare buffer
  } dpCtrl_t;
endpackage

// File: rtl/pattern_loader_dp.sv
module pattern_loader_dp
  import pattern_loader_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4096,
  parameter int BUFS   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtrl_t                     ctl,
  input  logic [$clog2(DEPTH):0]      lenData,
  input  logic [DATA_W-1:0]           inData,
  input  logic                        activeSel,
  output logic                        lenOk,
  output logic                        lenZero,
  output logic                        lastWord,
  output logic [BUFS-1:0]             memWe,
  output logic [$clog2(DEPTH)-1:0]    memAddr,
  output logic [DATA_W-1:0]           memData
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LEN_W  = ADDR_W + 1;

  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ <= '0;
      cntQ <= '0;
    end else if (ctl.lenLoad) begin
      lenQ <= lenData;
      cntQ <= '0;
    end else if (ctl.cntInc) begin
      cntQ <= cntQ + LEN_W'(1);
    end
  end

  assign lenZero  = (lenData == '0);
  assign lenOk    = !lenZero && (lenData <= LEN_W'(DEPTH));
  assign lastWord = ((cntQ + LEN_W'(1)) == lenQ);
  assign memAddr  = cntQ[ADDR_W-1:0];
  assign memData  = inData;

  // one enable per buffer; the spare one is the buffer not being played
  for (genvar b = 0; b < BUFS; b++) begin : gWe
    localparam logic BUF_ID = 1'(b);
    assign memWe[b] = ctl.wrEn && (activeSel != BUF_ID);
  end

  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memWe) && !memWe[activeSel]);

  assert_addr_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> (cntQ < LEN_W'(DEPTH)));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntInc && !ctl.lenLoad |=> cntQ == $past(cntQ) + LEN_W'(1));
endmodule

// File: rtl/pattern_loader_ctrl.sv
module pattern_loader_ctrl
  import pattern_loader_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lenWe,
  input  logic    lenOk,
  input  logic    lenZero,
  input  logic    inValid,
  input  logic    lastWord,
  input  logic    activeSel,
  input  logic    errClear,
  output dpCtrl_t ctl,
  output logic    inReady,
  output logic    busy,
  output logic    done,
  output logic    overrunErr,
  output logic    preloadFull
);
  loadState_e stateQ, stateD;
  logic doneQ, ovQ, pfQ, selQ;
  logic accept, finish, zeroDone, swapSeen, ovSet;

  assign inReady  = (stateQ != ST_IDLE);
  assign busy     = (stateQ == ST_LOAD);
  assign accept   = inValid && inReady;
  assign finish   = accept && lastWord;
  assign zeroDone = (stateQ == ST_IDLE) && lenWe && lenZero;
  assign swapSeen = (activeSel != selQ);
  assign ovSet    = swapSeen && busy;

  always_comb begin
    ctl         = '0;
    ctl.lenLoad = (stateQ == ST_IDLE) && lenWe && lenOk;
    ctl.cntInc  = accept;
    ctl.wrEn    = accept;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (ctl.lenLoad) stateD = ST_ARMED;
      ST_ARMED: if (accept) stateD = lastWord ? ST_IDLE : ST_LOAD;
      ST_LOAD:  if (finish) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      ovQ    <= 1'b0;
      pfQ    <= 1'b0;
      selQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= finish || zeroDone;
      selQ   <= activeSel;
      if (ovSet)         ovQ <= 1'b1;
      else if (errClear) ovQ <= 1'b0;
      if (finish || zeroDone) pfQ <= 1'b1;
      else if (swapSeen)      pfQ <= 1'b0;
    end
  end

  assign done        = doneQ;
  assign overrunErr  = ovQ;
  assign preloadFull = pfQ;

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && lastWord |=> done && !inReady && !busy);

  assert_zero_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    !inReady && lenWe && lenZero |=> done && !inReady);

  assert_busy_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> inReady);

  assert_ov_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr && !errClear |=> overrunErr);

  assert_ov_swap_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy && (activeSel != selQ) |=> overrunErr);

  assert_pf_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> preloadFull);
endmodule

// File: rtl/pattern_loader.sv
module pattern_loader
  import pattern_loader_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4096
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lenWe,
  input  logic [$clog2(DEPTH):0]     lenData,
  input  logic                       inValid,
  input  logic [DATA_W-1:0]          inData,
  output logic                       inReady,
  input  logic                       seqActiveSel,
  input  logic                       errClear,
  output logic [1:0]                 memWe,
  output logic [$clog2(DEPTH)-1:0]   memAddr,
  output logic [DATA_W-1:0]          memData,
  output logic                       busy,
  output logic                       done,
  output logic                       overrunErr,
  output logic                       preloadFull
);
  localparam int BUFS = 2;

  dpCtrl_t ctl;
  logic    lenOk, lenZero, lastWord;

  pattern_loader_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lenWe(lenWe), .lenOk(lenOk), .lenZero(lenZero),
    .inValid(inValid), .lastWord(lastWord), .activeSel(seqActiveSel),
    .errClear(errClear), .ctl(ctl), .inReady(inReady), .busy(busy),
    .done(done), .overrunErr(overrunErr), .preloadFull(preloadFull)
  );

  pattern_loader_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BUFS(BUFS)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lenData(lenData), .inData(inData),
    .activeSel(seqActiveSel), .lenOk(lenOk), .lenZero(lenZero),
    .lastWord(lastWord), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: tb/pattern_loader_test.sv
module pattern_loader_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lenWe = 1'b0;
  logic [12:0] lenData = '0;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        inReady;
  logic        seqActiveSel = 1'b0;
  logic        errClear = 1'b0;
  logic [1:0]  memWe;
  logic [11:0] memAddr;
  logic [15:0] memData;
  logic        busy, done, overrunErr, preloadFull;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic expOv = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  pattern_loader uut (
    .clk(clk), .rstN(rstN), .lenWe(lenWe), .lenData(lenData),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .seqActiveSel(seqActiveSel), .errClear(errClear), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .busy(busy), .done(done),
    .overrunErr(overrunErr), .preloadFull(preloadFull)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected enable: the buffer opposite the played one
  function automatic int spareWe(input logic sel);
    return sel ? 1 : 2;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one transfer; swapAt/clearAt = word index where sel flips / errClear pulses
  task automatic doLoad(input int len, input int swapAt, input int clearAt,
                        input bit gaps);
    logic newOv;
    lenWe = 1'b1; lenData = 13'(len);
    step();
    lenWe = 1'b0;
    check("R2 armed", inReady, 1);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        inValid = 1'b0;
        #1 check("R10 gap no write", memWe, 0);
        step();
      end
      inValid = 1'b1;
      inData  = 16'($urandom);
      newOv   = 1'b0;
      if (i == swapAt) begin
        newOv = (i > 0);  // busy is high from the second word on
        seqActiveSel = ~seqActiveSel;
      end
      errClear = (i == clearAt);
      #1;
      check("R5 spare buffer", memWe, spareWe(seqActiveSel));
      check("R4 address", memAddr, i % 4096);
      check("R4 data", memData, inData);
      if (newOv) expOv = 1'b1;
      else if (errClear) expOv = 1'b0;
      step();
      errClear = 1'b0;
      check("R8 overrun", overrunErr, expOv);
      if (i < len - 1) begin
        check("R7 busy", busy, 1);
        check("R6 no early done", done, 0);
      end else begin
        check("R6 done", done, 1);
        check("R6 ready low", inReady, 0);
        check("R7 busy low", busy, 0);
        check("R9 preload full", preloadFull, 1);
      end
    end
    inValid = 1'b0;
    step();
    check("R6 done pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) step();
    check("R1 inReady", inReady, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 overrun", overrunErr, 0);
    check("R1 preloadFull", preloadFull, 0);
    check("R1 memWe", memWe, 0);
    rstN = 1'b1;
    step();

    // R10: words while idle
    inValid = 1'b1; inData = 16'hBEEF;
    #1 check("R10 idle no write", memWe, 0);
    step();
    inValid = 1'b0;

    // R3: zero length
    lenWe = 1'b1; lenData = 13'd0;
    #1 check("R3 no write", memWe, 0);
    step();
    lenWe = 1'b0;
    check("R3 done", done, 1);
    check("R3 not ready", inReady, 0);
    check("R9 zero completion", preloadFull, 1);
    step();
    check("R3 done pulse", done, 0);

    // R9: swap while idle clears preloadFull, leaves overrun alone
    seqActiveSel = 1'b1;
    step();
    step();
    check("R9 cleared by swap", preloadFull, 0);
    check("R8 idle swap ignored", overrunErr, 0);

    // R2: oversize length ignored
    lenWe = 1'b1; lenData = 13'd4097;
    step();
    lenWe = 1'b0;
    check("R2 oversize ignored", inReady, 0);
    step();
    check("R2 oversize no done", done, 0);

    // R2: length write while armed is ignored (armed length stays 3)
    lenWe = 1'b1; lenData = 13'd3;
    step();
    lenData = 13'd10;
    step();
    lenWe = 1'b0;
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1; inData = 16'(i + 7);
      #1 check("R4 address rearm", memAddr, i);
      step();
    end
    inValid = 1'b0;
    check("R2 second write ignored", done, 1);
    step();

    // one-word transfer: busy never rises
    doLoad(1, -1, -1, 1'b0);

    // swap on first word: not busy, no overrun
    doLoad(4, 0, -1, 1'b0);

    // swap mid-load: overrun, then clear in same cycle as another swap
    doLoad(6, 2, -1, 1'b0);
    doLoad(5, 3, 3, 1'b0);
    check("R8 set wins over clear", overrunErr, 1);
    errClear = 1'b1;
    step();
    errClear = 1'b0;
    expOv = 1'b0;
    check("R8 cleared", overrunErr, 0);

    // swap on the final word
    doLoad(5, 4, -1, 1'b0);
    errClear = 1'b1; step(); errClear = 1'b0; expOv = 1'b0;

    // random transfers with gaps
    for (int t = 0; t < 20; t++) begin
      int len = 1 + ($urandom % 40);
      int sw  = ($urandom % 3 == 0) ? int'($urandom % len) : -1;
      doLoad(len, sw, -1, 1'b1);
      if (expOv) begin
        errClear = 1'b1; step(); errClear = 1'b0; expOv = 1'b0;
      end
    end

    // full-depth boundary
    doLoad(4096, -1, -1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule